// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block moves 36-bit words from a write clock domain to an unrelated read clock domain. It keeps them in a memory whose depth is a power-of-two parameter. The write side accepts a word on every write-clock edge where `wr_en` is high and `in_rdy` is high. The read side shows the oldest word on a registered output, `rd_data`, without being asked for it (first-word fall-through). `out_rdy` tells the reader that `rd_data` holds a valid word, and a read with `rd_en` pops that word.

Each side also has a threshold flag. On the read side, `ae_n` is low while the memory holds few words. On the write side, `af_n` is low while the memory is close to full. The word that sits in the output register has already left the memory, so it is not part of the fill level that the flags compare. The two thresholds take preset values at reset, and the write side can reload them through a small programming port.

The read and write pointers cross between the domains as Gray codes through two-stage synchronizers. For this reason, any flag that reacts to an event on the other side changes on the second edge of its own clock after that event.

Top module: `xdom_flag_fifo`

## Requirements
- R1: Words leave on `rd_data` in the order they were accepted, bit for bit, across all 36 bits.
- R2: A word written into an empty FIFO appears on `rd_data` with `out_rdy` high and no `rd_en`. While `out_rdy` is high and `rd_en` is low, `rd_data` and `out_rdy` hold.
- R3: `in_rdy` is low exactly when the memory holds DEPTH words. The word in the output register is not counted, so the FIFO can hold DEPTH+1 words in total. A write attempted while `in_rdy` is low is dropped.
- R4: A read attempted while `out_rdy` is low is dropped and does not disturb later data.
- R5: `ae_n` is low while the memory count is at or below the almost-empty offset X, and high once the count reaches X+1.
- R6: `af_n` is low while the memory count is at or above DEPTH−Y, and high below that level. Y is the almost-full offset.
- R7: After a read frees a slot in a full memory, `in_rdy` is still low after the first write-clock edge and high after the second. After the write that raises the memory count to X+1, `ae_n` is still low after the first read-clock edge and high after the second.
- R8: After reset, `in_rdy` is high, `out_rdy` is low, `ae_n` is low, `af_n` is high, and X and Y equal the parameters AE_PRESET and AF_PRESET.
- R9: On a write-clock edge with `prog_en` high, `prog_val` loads X when `prog_sel` is 0 and loads Y when `prog_sel` is 1. While `prog_en` is low, `prog_sel` and `prog_val` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| in_rdy | output | 1 | High while the memory has a free slot |
| af_n | output | 1 | Low while the memory count is at or above DEPTH−Y |
| prog_en | input | 1 | Load an offset on this edge |
| prog_sel | input | 1 | 0 selects X (almost-empty), 1 selects Y (almost-full) |
| prog_val | input | log2(DEPTH)+1 | Offset value to load |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Pop the word shown on `rd_data` |
| rd_data | output | WIDTH | Oldest word, registered |
| out_rdy | output | 1 | High while `rd_data` is valid |
| ae_n | output | 1 | Low while the memory count is at or below X |

## Verification
The bound checker watches properties that hold on every edge:
- a blocked write never moves the write pointer, and an accepted write moves it by exactly one;
- the write-side fill never exceeds DEPTH;
- the Gray pointer changes at most one bit per edge;
- a full memory always shows `af_n` low;
- the output word holds while it is not popped.

Some behaviours can only be shown by the bench's scenarios:
- the flag thresholds under preset and reprogrammed offsets;
- the exact second-edge timing of `in_rdy` and `ae_n`;
- the fact that the fall-through word is left out of the count;
- the end-to-end order of the data.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;

  localparam int GW = 32;

  function automatic logic [GW-1:0] gray_to_bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW-2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic logic [GW-1:0] bin_to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int W  = 36,
  parameter int AW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [AW:0] AE_PRESET = '0,
  parameter logic [AW:0] AF_PRESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rd_gray_async,
  input  logic          prog_en,
  input  logic          prog_sel,
  input  logic [AW:0]   prog_val,
  output logic [AW:0]   wr_ptr,
  output logic [AW:0]   wr_gray,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          in_rdy,
  output logic          af_n,
  output logic [AW:0]   ae_ofs,
  output logic [AW:0]   fill
);

  localparam int            PW       = AW + 1;
  localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};
  localparam logic [AW+1:0] LIMIT    = {2'b01, {AW{1'b0}}};

  logic [AW:0] rd_gray_s;
  logic [AW:0] rd_bin;
  logic [AW:0] wr_ptr_nx;
  logic [AW:0] af_ofs;

  dcf_sync2 #(.W(PW), .RST_VAL('0)) u_rsync (
    .clk (clk),
    .rst (rst),
    .d   (rd_gray_async),
    .q   (rd_gray_s)
  );

  always_comb begin
    rd_bin    = PW'(gray_to_bin(GW'(rd_gray_s)));
    fill      = wr_ptr - rd_bin;
    in_rdy    = (fill != FULL_CNT);
    af_n      = ({1'b0, fill} + {1'b0, af_ofs}) < LIMIT;
    mem_we    = wr_en && in_rdy;
    mem_addr  = wr_ptr[AW-1:0];
    wr_ptr_nx = wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wr_gray <= '0;
    end else if (mem_we) begin
      wr_ptr  <= wr_ptr_nx;
      wr_gray <= PW'(bin_to_gray(GW'(wr_ptr_nx)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ae_ofs <= AE_PRESET;
      af_ofs <= AF_PRESET;
    end else if (prog_en) begin
      if (ofs_sel_e'(prog_sel) == OFS_FULL) af_ofs <= prog_val;
      else                                  ae_ofs <= prog_val;
    end
  end

endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [AW:0] AE_PRESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wr_gray_async,
  input  logic [AW:0]   ae_ofs_async,
  output logic [AW:0]   rd_ptr,
  output logic [AW:0]   rd_gray,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          out_rdy,
  output logic          ae_n,
  output logic [AW:0]   fill
);

  localparam int PW = AW + 1;

  logic [AW:0] wr_gray_s;
  logic [AW:0] wr_bin;
  logic [AW:0] ae_ofs_s;
  logic [AW:0] rd_ptr_nx;

  dcf_sync2 #(.W(PW), .RST_VAL('0)) u_wsync (
    .clk (clk),
    .rst (rst),
    .d   (wr_gray_async),
    .q   (wr_gray_s)
  );

  // The offset is quasi-static: it is changed only while the FIFO is idle.
  dcf_sync2 #(.W(PW), .RST_VAL(AE_PRESET)) u_osync (
    .clk (clk),
    .rst (rst),
    .d   (ae_ofs_async),
    .q   (ae_ofs_s)
  );

  always_comb begin
    wr_bin    = PW'(gray_to_bin(GW'(wr_gray_s)));
    fill      = wr_bin - rd_ptr;
    mem_re    = (fill != '0) && (!out_rdy || rd_en);
    mem_addr  = rd_ptr[AW-1:0];
    ae_n      = fill > ae_ofs_s;
    rd_ptr_nx = rd_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      rd_gray <= '0;
      out_rdy <= 1'b0;
    end else if (mem_re) begin
      rd_ptr  <= rd_ptr_nx;
      rd_gray <= PW'(bin_to_gray(GW'(rd_ptr_nx)));
      out_rdy <= 1'b1;
    end else if (rd_en) begin
      out_rdy <= 1'b0;
    end
  end

endmodule

// File: rtl/xdom_flag_fifo.sv
`timescale 1ns/1ps
module xdom_flag_fifo #(
  parameter int WIDTH     = 36,
  parameter int DEPTH     = 256,
  parameter int AE_PRESET = 8,
  parameter int AF_PRESET = 8
) (
  input  logic                   wr_clk,
  input  logic                   wr_rst,
  input  logic                   wr_en,
  input  logic [WIDTH-1:0]       wr_data,
  output logic                   in_rdy,
  output logic                   af_n,
  input  logic                   prog_en,
  input  logic                   prog_sel,
  input  logic [$clog2(DEPTH):0] prog_val,
  input  logic                   rd_clk,
  input  logic                   rd_rst,
  input  logic                   rd_en,
  output logic [WIDTH-1:0]       rd_data,
  output logic                   out_rdy,
  output logic                   ae_n
);

  localparam int          AW     = $clog2(DEPTH);
  localparam logic [AW:0] AE_INI = (AW+1)'(AE_PRESET);
  localparam logic [AW:0] AF_INI = (AW+1)'(AF_PRESET);

  logic [AW:0]   wr_ptr, wr_gray, wr_fill, ae_ofs;
  logic [AW:0]   rd_ptr, rd_gray, rd_fill;
  logic          mem_we, mem_re;
  logic [AW-1:0] waddr, raddr;

  dcf_wr_ctl #(.AW(AW), .AE_PRESET(AE_INI), .AF_PRESET(AF_INI)) u_wr (
    .clk           (wr_clk),
    .rst           (wr_rst),
    .wr_en         (wr_en),
    .rd_gray_async (rd_gray),
    .prog_en       (prog_en),
    .prog_sel      (prog_sel),
    .prog_val      (prog_val),
    .wr_ptr        (wr_ptr),
    .wr_gray       (wr_gray),
    .mem_we        (mem_we),
    .mem_addr      (waddr),
    .in_rdy        (in_rdy),
    .af_n          (af_n),
    .ae_ofs        (ae_ofs),
    .fill          (wr_fill)
  );

  dcf_rd_ctl #(.AW(AW), .AE_PRESET(AE_INI)) u_rd (
    .clk           (rd_clk),
    .rst           (rd_rst),
    .rd_en         (rd_en),
    .wr_gray_async (wr_gray),
    .ae_ofs_async  (ae_ofs),
    .rd_ptr        (rd_ptr),
    .rd_gray       (rd_gray),
    .mem_re        (mem_re),
    .mem_addr      (raddr),
    .out_rdy       (out_rdy),
    .ae_n          (ae_n),
    .fill          (rd_fill)
  );

  dcf_ram #(.W(WIDTH), .AW(AW)) u_ram (
    .wr_clk (wr_clk),
    .we     (mem_we),
    .waddr  (waddr),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .re     (mem_re),
    .raddr  (raddr),
    .rdata  (rd_data)
  );

endmodule

// File: rtl/xdom_flag_fifo_chk.sv
`timescale 1ns/1ps
module xdom_flag_fifo_chk #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             wr_en,
  input logic             in_rdy,
  input logic             af_n,
  input logic [AW:0]      wr_ptr,
  input logic [AW:0]      wr_gray,
  input logic [AW:0]      wr_fill,
  input logic [AW:0]      rd_ptr,
  input logic [AW:0]      rd_fill,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             rd_en,
  input logic             out_rdy,
  input logic [WIDTH-1:0] rd_data
);

  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_fill <= FULL_CNT);

  a_r3_blocked_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && !in_rdy) |=> $stable(wr_ptr));

  a_r1_wr_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && in_rdy) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  a_r7_gray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

  a_r6_full_af: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !in_rdy |-> !af_n);

  a_r2_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (out_rdy && !rd_en) |=> (out_rdy && $stable(rd_data)));

  a_r4_read_bound: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_fill == '0) |=> $stable(rd_ptr));

endmodule

bind xdom_flag_fifo xdom_flag_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .wr_clk  (wr_clk),
  .wr_rst  (wr_rst),
  .wr_en   (wr_en),
  .in_rdy  (in_rdy),
  .af_n    (af_n),
  .wr_ptr  (wr_ptr),
  .wr_gray (wr_gray),
  .wr_fill (wr_fill),
  .rd_ptr  (rd_ptr),
  .rd_fill (rd_fill),
  .rd_clk  (rd_clk),
  .rd_rst  (rd_rst),
  .rd_en   (rd_en),
  .out_rdy (out_rdy),
  .rd_data (rd_data)
);

// File: tb/xdom_flag_fifo_bench.sv
`timescale 1ns/1ps
module xdom_flag_fifo_bench;

  localparam int WIDTH = 36;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int NV    = 10;

  // {push attempts, pop attempts, expected {out_rdy, in_rdy, ae_n, af_n}}
  // Offsets during the table: X = 2, Y = 3.
  localparam logic [19:0] VEC [NV] = '{
    {8'd1,  8'd0,  4'b1101},
    {8'd3,  8'd0,  4'b1111},
    {8'd0,  8'd2,  4'b1101},
    {8'd12, 8'd0,  4'b1110},
    {8'd3,  8'd0,  4'b1010},
    {8'd2,  8'd0,  4'b1010},
    {8'd0,  8'd1,  4'b1110},
    {8'd0,  8'd3,  4'b1111},
    {8'd0,  8'd13, 4'b0101},
    {8'd0,  8'd2,  4'b0101}
  };

  logic             wr_clk = 1'b0;
  logic             rd_clk = 1'b0;
  logic             wr_rst = 1'b1;
  logic             rd_rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             in_rdy, af_n, out_rdy, ae_n;
  logic             prog_en = 1'b0;
  logic             prog_sel = 1'b0;
  logic [AW:0]      prog_val = '0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] rd_data;

  int               n_chk = 0;
  int               n_fail = 0;
  int               cnt = 0;
  bit               done = 1'b0;
  logic [WIDTH-1:0] q [$];
  logic [WIDTH-1:0] held;

  always #10   wr_clk = ~wr_clk;
  always #13.5 rd_clk = ~rd_clk;

  xdom_flag_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AE_PRESET(2), .AF_PRESET(3)) u_xdom_flag_fifo (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .in_rdy   (in_rdy),
    .af_n     (af_n),
    .prog_en  (prog_en),
    .prog_sel (prog_sel),
    .prog_val (prog_val),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .out_rdy  (out_rdy),
    .ae_n     (ae_n)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = WIDTH'({32'(cnt) * 32'h9E3779B1, 4'(cnt)});
      cnt++;
      if (in_rdy) q.push_back(wr_data);
      @(posedge wr_clk);
      #0.2 wr_en = 1'b0;
    end
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_en = 1'b1;
      if (out_rdy) begin
        if (q.size() == 0) check("R4 data with empty model", 64'(rd_data), 64'hx);
        else begin
          check("R1 read order", 64'(rd_data), 64'(q[0]));
          void'(q.pop_front());
        end
      end
      @(posedge rd_clk);
      #0.2 rd_en = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic flags(input string tag, input logic [3:0] exp);
    check({tag, " R2 out_rdy"}, 64'(out_rdy), 64'(exp[3]));
    check({tag, " R3 in_rdy"},  64'(in_rdy),  64'(exp[2]));
    check({tag, " R5 ae_n"},    64'(ae_n),    64'(exp[1]));
    check({tag, " R6 af_n"},    64'(af_n),    64'(exp[0]));
  endtask

  task automatic program_ofs(input logic sel, input logic [AW:0] val);
    @(negedge wr_clk);
    prog_en  = 1'b1;
    prog_sel = sel;
    prog_val = val;
    @(negedge wr_clk);
    prog_en  = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #200;
    @(negedge wr_clk) wr_rst = 1'b0;
    @(negedge rd_clk) rd_rst = 1'b0;
    settle();
    flags("reset R8", 4'b0101);

    // R2: fall-through of the first word with no read request
    push_n(1);
    settle();
    check("R2 fall-through data", 64'(rd_data), 64'(q[0]));
    pop_n(1);
    settle();

    for (int v = 0; v < NV; v++) begin
      push_n(int'(VEC[v][19:12]));
      pop_n(int'(VEC[v][11:4]));
      settle();
      flags($sformatf("vector %0d", v), VEC[v][3:0]);
    end

    // R4: the ignored reads above must not disturb the next word
    push_n(1);
    settle();
    check("R4 next word after ignored reads", 64'(rd_data), 64'(q[0]));
    pop_n(1);
    settle();

    // R7: in_rdy recovers on the second write edge after a read
    push_n(17);
    settle();
    check("R3 full memory", 64'(in_rdy), 64'd0);
    @(negedge rd_clk);
    rd_en = 1'b1;
    check("R1 read order", 64'(rd_data), 64'(q[0]));
    void'(q.pop_front());
    @(posedge rd_clk);
    #0.2 rd_en = 1'b0;
    @(posedge wr_clk);
    #0.2 check("R7 in_rdy after first write edge", 64'(in_rdy), 64'd0);
    @(posedge wr_clk);
    #0.2 check("R7 in_rdy after second write edge", 64'(in_rdy), 64'd1);
    pop_n(16);
    settle();

    // R7: ae_n rises on the second read edge after the write reaching X+1
    push_n(3);
    settle();
    check("R5 memory count equals X", 64'(ae_n), 64'd0);
    push_n(1);
    @(posedge rd_clk);
    #0.2 check("R7 ae_n after first read edge", 64'(ae_n), 64'd0);
    @(posedge rd_clk);
    #0.2 check("R7 ae_n after second read edge", 64'(ae_n), 64'd1);
    pop_n(4);
    settle();
    check("R2 drained", 64'(out_rdy), 64'd0);

    // R2: output holds while not popped
    push_n(2);
    settle();
    held = rd_data;
    repeat (5) @(posedge rd_clk);
    #0.2 check("R2 hold data", 64'(rd_data), 64'(held));
    check("R2 hold valid", 64'(out_rdy), 64'd1);
    pop_n(2);
    settle();

    // R9: program X = 5, Y = 1, then wiggle the port with prog_en low
    program_ofs(1'b0, 5'd5);
    program_ofs(1'b1, 5'd1);
    @(negedge wr_clk);
    prog_sel = 1'b0;
    prog_val = 5'd0;
    repeat (3) @(negedge wr_clk);
    prog_sel = 1'b1;
    prog_val = 5'd15;
    settle();
    push_n(6);
    settle();
    check("R9 X=5 at count 5", 64'(ae_n), 64'd0);
    push_n(1);
    settle();
    check("R9 X=5 at count 6", 64'(ae_n), 64'd1);
    push_n(8);
    settle();
    check("R9 Y=1 at count 14", 64'(af_n), 64'd1);
    push_n(1);
    settle();
    check("R9 Y=1 at count 15", 64'(af_n), 64'd0);
    pop_n(20);
    settle();
    check("R1 model drained", 64'(q.size()), 64'd0);
    check("R2 empty at end", 64'(out_rdy), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule